// File: doc/BRIEF.md
# Write-Through Write-Allocate Cache

This block sits between a processor load/store port and a word-wide memory port. It holds a small fully associative set of lines, each caching a block of consecutive words, and keeps only a valid bit and a tag per line. Loads that hit are answered from the cache without touching memory. Any miss, whether the access is a load or a store, first brings the whole block into a line and then completes the access. Every store, hit or miss, also writes its single word to memory straight away, so memory is never stale. Because of that, a replaced line is simply overwritten and is never copied back.

The processor hands over one request at a time with a valid/ready handshake. `cpu_req_ready` is high only while the block is idle. Once a request is taken, `stall` stays high until the block answers with a one-cycle `cpu_rsp_valid` pulse. The stalled processor must take that pulse; the response path has no back-pressure. On the memory side the block presents one request at a time on a valid/ready channel. A request stays stable until `mem_req_ready` is seen high. A read request is answered later by exactly one `mem_rsp_valid` beat. A write request is complete at its handshake. Two saturating counters report the hits and misses seen since reset.

The default configuration has a 5-bit address with a 4-bit tag and a 1-bit word offset (two words per block), two lines, 8-bit data and 8-bit counters.

Top module: `wt_cache`

## Requirements
- R1: After reset every line is invalid, both counters read zero, `stall` is low and `cpu_req_ready` is high, so the first access to any address is a miss.
- R2: A load whose tag matches a valid line returns the cached word, makes no memory request and raises `hit_count` by one.
- R3: A miss (load or store) raises `miss_count` by one and issues exactly two memory reads, for the block's word 0 and then word 1. The read address is the request tag followed by the word index in the low bit.
- R4: A load that misses returns the memory word at the requested address once the block has been filled.
- R5: Every store issues exactly one memory write, carrying the store's own address and data. On a miss, that write follows the block refill.
- R6: A store updates the cached copy, so a later load of the same address hits and returns the stored data.
- R7: A store miss allocates the block, so a later load of the other word of that block hits.
- R8: The victim on a miss is an invalid line when one exists; otherwise it is the least recently used line, where both a hit and a fill count as a use. Replacing a line never issues a memory write.
- R9: Each counter goes up by at most one per access and holds at its all-ones value instead of wrapping.
- R10: From the cycle after a request is accepted until its response, `stall` is high and `cpu_req_ready` is low. Each request gets exactly one single-cycle `cpu_rsp_valid` pulse.
- R11: While `mem_req_valid` is high and `mem_req_ready` is low, the memory request (valid, write flag, address and data) is held unchanged into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Block can accept a request (idle) |
| cpu_req_we | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | ADDR_W | Word address |
| cpu_req_wdata | input | DATA_W | Store data |
| cpu_rsp_valid | output | 1 | One-cycle completion pulse |
| cpu_rsp_rdata | output | DATA_W | Load data, valid with the pulse |
| stall | output | 1 | Request in progress |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 = word write, 0 = word read |
| mem_req_addr | output | ADDR_W | Memory word address |
| mem_req_wdata | output | DATA_W | Memory write data |
| mem_rsp_valid | input | 1 | Read data beat |
| mem_rsp_rdata | input | DATA_W | Read data |
| hit_count | output | CNT_W | Saturating hit counter |
| miss_count | output | CNT_W | Saturating miss counter |

## Verification
The bound checker covers the rules that hold on every cycle. It checks the handshake discipline: a request held under memory back-pressure, no memory traffic while idle, and stall raised after acceptance and dropped at the response. It also checks that the counters step by at most one and stick at their maximum. Whether a given access should hit, which line is replaced, the order and addresses of refill reads, and the value a load returns depend on the access history. Only the bench's sweeps show these, comparing against an arithmetic model of tags and recency.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_FILL_REQ,
    ST_FILL_WAIT,
    ST_WRITE
  } wtc_state_e;
endpackage

// File: rtl/wtc_tag_store.sv
module wtc_tag_store #(
  parameter int LINES = 2,
  parameter int TAG_W = 4,
  parameter int IDX_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TAG_W-1:0] lk_tag,
  input  logic             alloc_en,
  input  logic [IDX_W-1:0] alloc_line,
  input  logic [TAG_W-1:0] alloc_tag,
  input  logic             commit_en,
  input  logic [IDX_W-1:0] commit_line,
  output logic             hit,
  output logic [IDX_W-1:0] hit_line,
  output logic [LINES-1:0] valid_vec
);
  logic [TAG_W-1:0] tags [LINES];
  logic [LINES-1:0] match;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_vec[g] <= 1'b0;
        tags[g]      <= '0;
      end else if (alloc_en && alloc_line == IDX_W'(g)) begin
        valid_vec[g] <= 1'b0;
        tags[g]      <= alloc_tag;
      end else if (commit_en && commit_line == IDX_W'(g)) begin
        valid_vec[g] <= 1'b1;
      end
    end
    assign match[g] = valid_vec[g] && (tags[g] == lk_tag);
  end

  assign hit = |match;

  always_comb begin
    hit_line = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (match[i]) hit_line = IDX_W'(i);
    end
  end
endmodule

// File: rtl/wtc_lru.sv
module wtc_lru #(
  parameter int LINES = 2,
  parameter int IDX_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_line,
  input  logic [LINES-1:0] valid_vec,
  output logic [IDX_W-1:0] victim
);
  localparam logic [IDX_W-1:0] OLDEST = IDX_W'(LINES - 1);

  logic [IDX_W-1:0] age [LINES];
  logic [IDX_W-1:0] touched_age;

  assign touched_age = age[touch_line];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) age[i] <= IDX_W'(LINES - 1 - i);
    end else if (touch_en) begin
      for (int i = 0; i < LINES; i++) begin
        if (IDX_W'(i) == touch_line) age[i] <= '0;
        else if (age[i] < touched_age) age[i] <= age[i] + 1'b1;
      end
    end
  end

  always_comb begin
    logic found;
    found  = 1'b0;
    victim = '0;
    for (int i = 0; i < LINES; i++) begin
      if (!found && !valid_vec[i]) begin
        victim = IDX_W'(i);
        found  = 1'b1;
      end
    end
    for (int i = 0; i < LINES; i++) begin
      if (!found && age[i] == OLDEST) begin
        victim = IDX_W'(i);
        found  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/wtc_data_store.sv
module wtc_data_store #(
  parameter int LINES  = 2,
  parameter int OFF_W  = 1,
  parameter int DATA_W = 8,
  parameter int IDX_W  = 1
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  wline,
  input  logic [OFF_W-1:0]  wword,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  rline,
  input  logic [OFF_W-1:0]  rword,
  output logic [DATA_W-1:0] rdata
);
  localparam int SLOTS = 1 << (IDX_W + OFF_W);

  logic [DATA_W-1:0] words [SLOTS];

  always_ff @(posedge clk) begin
    if (we) words[{wline, wword}] <= wdata;
  end

  assign rdata = words[{rline, rword}];
endmodule

// File: rtl/wtc_sat_cnt.sv
module wtc_sat_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else if (inc && !(&count)) count <= count + 1'b1;
  end
endmodule

// File: rtl/wt_cache.sv
module wt_cache #(
  parameter int ADDR_W = 5,
  parameter int OFF_W  = 1,
  parameter int DATA_W = 8,
  parameter int LINES  = 2,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_we,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_rsp_valid,
  output logic [DATA_W-1:0] cpu_rsp_rdata,
  output logic              stall,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_rdata,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  miss_count
);
  import wtc_pkg::*;

  localparam int TAG_W = ADDR_W - OFF_W;
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1;
  localparam logic [OFF_W-1:0] LAST_BEAT = '1;

  wtc_state_e        state;
  logic              req_we;
  logic [ADDR_W-1:0] req_addr;
  logic [DATA_W-1:0] req_wdata;
  logic [IDX_W-1:0]  fill_line;
  logic [OFF_W-1:0]  beat;
  logic              refilled;

  logic [TAG_W-1:0]  req_tag;
  logic [OFF_W-1:0]  req_off;
  logic              hit;
  logic [IDX_W-1:0]  hit_line;
  logic [LINES-1:0]  valid_vec;
  logic [IDX_W-1:0]  victim;
  logic [DATA_W-1:0] rd_word;

  logic              in_lookup;
  logic              fill_beat;
  logic              commit_en;
  logic              alloc_en;
  logic              touch_en;
  logic [IDX_W-1:0]  touch_line;
  logic              dwe;
  logic [IDX_W-1:0]  dline;
  logic [OFF_W-1:0]  dword;
  logic [DATA_W-1:0] dwdata;

  assign req_tag = req_addr[ADDR_W-1:OFF_W];
  assign req_off = req_addr[OFF_W-1:0];

  assign in_lookup  = (state == ST_LOOKUP);
  assign fill_beat  = (state == ST_FILL_WAIT) && mem_rsp_valid;
  assign commit_en  = fill_beat && (beat == LAST_BEAT);
  assign alloc_en   = in_lookup && !hit;
  assign touch_en   = (in_lookup && hit) || commit_en;
  assign touch_line = in_lookup ? hit_line : fill_line;

  always_comb begin
    dwe    = 1'b0;
    dline  = fill_line;
    dword  = beat;
    dwdata = mem_rsp_rdata;
    if (fill_beat) begin
      dwe = 1'b1;
    end else if (in_lookup && hit && req_we) begin
      dwe    = 1'b1;
      dline  = hit_line;
      dword  = req_off;
      dwdata = req_wdata;
    end
  end

  wtc_tag_store #(.LINES(LINES), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_tags (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_tag     (req_tag),
    .alloc_en   (alloc_en),
    .alloc_line (victim),
    .alloc_tag  (req_tag),
    .commit_en  (commit_en),
    .commit_line(fill_line),
    .hit        (hit),
    .hit_line   (hit_line),
    .valid_vec  (valid_vec)
  );

  wtc_lru #(.LINES(LINES), .IDX_W(IDX_W)) u_lru (
    .clk       (clk),
    .rst_n     (rst_n),
    .touch_en  (touch_en),
    .touch_line(touch_line),
    .valid_vec (valid_vec),
    .victim    (victim)
  );

  wtc_data_store #(.LINES(LINES), .OFF_W(OFF_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_data (
    .clk  (clk),
    .we   (dwe),
    .wline(dline),
    .wword(dword),
    .wdata(dwdata),
    .rline(hit_line),
    .rword(req_off),
    .rdata(rd_word)
  );

  wtc_sat_cnt #(.W(CNT_W)) u_hits (
    .clk  (clk),
    .rst_n(rst_n),
    .inc  (in_lookup && hit && !refilled),
    .count(hit_count)
  );

  wtc_sat_cnt #(.W(CNT_W)) u_misses (
    .clk  (clk),
    .rst_n(rst_n),
    .inc  (alloc_en),
    .count(miss_count)
  );

  assign cpu_req_ready = (state == ST_IDLE);
  assign stall         = (state != ST_IDLE);
  assign mem_req_valid = (state == ST_FILL_REQ) || (state == ST_WRITE);
  assign mem_req_we    = (state == ST_WRITE);
  assign mem_req_addr  = (state == ST_WRITE) ? req_addr : {req_tag, beat};
  assign mem_req_wdata = req_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state         <= ST_IDLE;
      req_we        <= 1'b0;
      req_addr      <= '0;
      req_wdata     <= '0;
      fill_line     <= '0;
      beat          <= '0;
      refilled      <= 1'b0;
      cpu_rsp_valid <= 1'b0;
      cpu_rsp_rdata <= '0;
    end else begin
      cpu_rsp_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (cpu_req_valid) begin
            req_we    <= cpu_req_we;
            req_addr  <= cpu_req_addr;
            req_wdata <= cpu_req_wdata;
            refilled  <= 1'b0;
            state     <= ST_LOOKUP;
          end
        end
        ST_LOOKUP: begin
          if (hit) begin
            if (req_we) begin
              state <= ST_WRITE;
            end else begin
              cpu_rsp_valid <= 1'b1;
              cpu_rsp_rdata <= rd_word;
              state         <= ST_IDLE;
            end
          end else begin
            fill_line <= victim;
            beat      <= '0;
            state     <= ST_FILL_REQ;
          end
        end
        ST_FILL_REQ: begin
          if (mem_req_ready) state <= ST_FILL_WAIT;
        end
        ST_FILL_WAIT: begin
          if (mem_rsp_valid) begin
            if (beat == LAST_BEAT) begin
              refilled <= 1'b1;
              state    <= ST_LOOKUP;
            end else begin
              beat  <= beat + 1'b1;
              state <= ST_FILL_REQ;
            end
          end
        end
        ST_WRITE: begin
          if (mem_req_ready) begin
            cpu_rsp_valid <= 1'b1;
            cpu_rsp_rdata <= req_wdata;
            state         <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wt_cache_chk.sv
module wt_cache_chk #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req_valid,
  input logic              cpu_req_ready,
  input logic              cpu_rsp_valid,
  input logic              stall,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_we,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic [DATA_W-1:0] mem_req_wdata,
  input logic [CNT_W-1:0]  hit_count,
  input logic [CNT_W-1:0]  miss_count
);
  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_we)
      && $stable(mem_req_addr) && $stable(mem_req_wdata));

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !stall |-> !mem_req_valid);

  p_accept_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req_valid && cpu_req_ready |=> stall && !cpu_req_ready);

  p_rsp_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid |-> !stall && $past(stall));

  p_rsp_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid |=> !cpu_rsp_valid);

  p_hit_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(hit_count) |-> hit_count == CNT_W'($past(hit_count) + 1'b1));

  p_miss_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(miss_count) |-> miss_count == CNT_W'($past(miss_count) + 1'b1));

  p_hit_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (&hit_count) |=> (&hit_count));

  p_miss_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (&miss_count) |=> (&miss_count));
endmodule

bind wt_cache wt_cache_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cpu_req_valid(cpu_req_valid),
  .cpu_req_ready(cpu_req_ready),
  .cpu_rsp_valid(cpu_rsp_valid),
  .stall        (stall),
  .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready),
  .mem_req_we   (mem_req_we),
  .mem_req_addr (mem_req_addr),
  .mem_req_wdata(mem_req_wdata),
  .hit_count    (hit_count),
  .miss_count   (miss_count)
);

// File: tb/wt_cache_tb.sv
module wt_cache_tb;
  localparam int AW = 5;
  localparam int DW = 8;
  localparam int CW = 8;
  localparam int NWORDS = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cpu_req_valid = 1'b0;
  logic          cpu_req_ready;
  logic          cpu_req_we = 1'b0;
  logic [AW-1:0] cpu_req_addr = '0;
  logic [DW-1:0] cpu_req_wdata = '0;
  logic          cpu_rsp_valid;
  logic [DW-1:0] cpu_rsp_rdata;
  logic          stall;
  logic          mem_req_valid;
  logic          mem_req_ready = 1'b0;
  logic          mem_req_we;
  logic [AW-1:0] mem_req_addr;
  logic [DW-1:0] mem_req_wdata;
  logic          mem_rsp_valid = 1'b0;
  logic [DW-1:0] mem_rsp_rdata = '0;
  logic [CW-1:0] hit_count;
  logic [CW-1:0] miss_count;

  always #2 clk = ~clk;

  wt_cache u_dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_we(cpu_req_we), .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
    .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_rdata(cpu_rsp_rdata), .stall(stall),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
    .hit_count(hit_count), .miss_count(miss_count)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // memory model with pseudo-random back-pressure
  logic [DW-1:0] mem [NWORDS];
  logic [7:0]    lfsr = 8'hA5;
  int            rd_cnt = 0;
  int            wr_cnt = 0;
  logic [AW-1:0] rd_log [4];
  logic [AW-1:0] wr_addr_last = '0;
  logic [DW-1:0] wr_data_last = '0;

  initial begin
    for (int i = 0; i < NWORDS; i++) mem[i] = DW'(i * 37 + 11);
  end

  always @(posedge clk) begin
    lfsr          <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_req_ready <= lfsr[0] | lfsr[2];
    mem_rsp_valid <= 1'b0;
    if (rst_n && mem_req_valid && mem_req_ready) begin
      if (mem_req_we) begin
        mem[mem_req_addr] <= mem_req_wdata;
        wr_addr_last      <= mem_req_addr;
        wr_data_last      <= mem_req_wdata;
        wr_cnt            <= wr_cnt + 1;
      end else begin
        mem_rsp_valid     <= 1'b1;
        mem_rsp_rdata     <= mem[mem_req_addr];
        rd_log[rd_cnt % 4] <= mem_req_addr;
        rd_cnt            <= rd_cnt + 1;
      end
    end
  end

  // R11 bench-side hold check
  logic          bp_prev = 1'b0;
  logic [AW-1:0] bp_addr = '0;
  logic          bp_we = 1'b0;
  always @(negedge clk) begin
    if (rst_n && bp_prev)
      chk(mem_req_valid && mem_req_addr == bp_addr && mem_req_we == bp_we, "R11",
          "request held under back-pressure", int'(mem_req_addr), int'(bp_addr));
    bp_prev = rst_n && mem_req_valid && !mem_req_ready;
    bp_addr = mem_req_addr;
    bp_we   = mem_req_we;
  end

  // reference model of tags and recency (two lines)
  logic [AW-2:0] m_tag [2];
  logic          m_val [2];
  int            m_lru = 0;
  logic [DW-1:0] exp_mem [NWORDS];
  int            exp_hits = 0;
  int            exp_miss = 0;
  int            last_hit = 0;

  task automatic access(input bit we, input logic [AW-1:0] addr, input logic [DW-1:0] wdata);
    logic [AW-2:0] tag;
    int line;
    bit h;
    int rd0, wr0;
    logic [DW-1:0] exp_rd;
    tag  = addr[AW-1:1];
    h    = 0;
    line = 0;
    for (int i = 0; i < 2; i++) if (m_val[i] && m_tag[i] == tag) begin h = 1; line = i; end
    if (!h) begin
      if (!m_val[0]) line = 0;
      else if (!m_val[1]) line = 1;
      else line = m_lru;
      m_val[line] = 1'b1;
      m_tag[line] = tag;
      if (exp_miss < 255) exp_miss++;
    end else if (exp_hits < 255) exp_hits++;
    m_lru  = 1 - line;
    exp_rd = exp_mem[addr];
    if (we) exp_mem[addr] = wdata;
    last_hit = h;

    rd0 = rd_cnt;
    wr0 = wr_cnt;
    @(negedge clk);
    while (!cpu_req_ready) @(negedge clk);
    cpu_req_valid = 1'b1;
    cpu_req_we    = we;
    cpu_req_addr  = addr;
    cpu_req_wdata = wdata;
    @(negedge clk);
    cpu_req_valid = 1'b0;
    chk(stall && !cpu_req_ready, "R10", "stall after accept", int'(stall), 1);
    while (!cpu_rsp_valid) @(negedge clk);
    if (!we) chk(cpu_rsp_rdata == exp_rd, h ? "R2" : "R4", "load data", int'(cpu_rsp_rdata), int'(exp_rd));
    chk(rd_cnt - rd0 == (h ? 0 : 2), h ? "R2" : "R3", "memory reads", rd_cnt - rd0, h ? 0 : 2);
    if (!h && rd_cnt - rd0 == 2) begin
      chk(rd_log[rd0 % 4] == {tag, 1'b0}, "R3", "refill word 0 address", int'(rd_log[rd0 % 4]), int'({tag, 1'b0}));
      chk(rd_log[(rd0 + 1) % 4] == {tag, 1'b1}, "R3", "refill word 1 address", int'(rd_log[(rd0 + 1) % 4]), int'({tag, 1'b1}));
    end
    chk(wr_cnt - wr0 == (we ? 1 : 0), we ? "R5" : "R8", "memory writes", wr_cnt - wr0, we ? 1 : 0);
    if (we) begin
      chk(wr_addr_last == addr, "R5", "write address", int'(wr_addr_last), int'(addr));
      chk(wr_data_last == wdata, "R5", "write data", int'(wr_data_last), int'(wdata));
    end
    chk(int'(hit_count) == exp_hits, "R2", "hit counter", int'(hit_count), exp_hits);
    chk(int'(miss_count) == exp_miss, "R3", "miss counter", int'(miss_count), exp_miss);
    @(negedge clk);
    chk(!cpu_rsp_valid && !stall, "R10", "single response pulse", int'(cpu_rsp_valid), 0);
  endtask

  always @(posedge clk) begin
    if (rst_n && $time > 400000) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 2; i++) begin m_val[i] = 1'b0; m_tag[i] = '0; end
    for (int i = 0; i < NWORDS; i++) exp_mem[i] = DW'(i * 37 + 11);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!stall && cpu_req_ready, "R1", "idle after reset", int'(stall), 0);
    chk(hit_count == 0 && miss_count == 0, "R1", "counters cleared", int'(hit_count) + int'(miss_count), 0);
    chk(!cpu_rsp_valid && !mem_req_valid, "R1", "no traffic after reset", int'(mem_req_valid), 0);

    access(1'b0, 5'd1, '0);
    chk(last_hit == 0, "R1", "first access misses", last_hit, 0);
    access(1'b0, 5'd7, '0);   // fills the other, still invalid line
    access(1'b0, 5'd0, '0);
    chk(last_hit == 1, "R8", "invalid line taken before valid one", last_hit, 1);
    access(1'b1, 5'd5, 8'h5A); // store miss evicts block of 7
    chk(last_hit == 0, "R7", "store miss", last_hit, 0);
    access(1'b0, 5'd4, '0);
    chk(last_hit == 1, "R7", "store miss allocated block", last_hit, 1);
    access(1'b0, 5'd5, '0);
    chk(last_hit == 1 && cpu_rsp_rdata == 8'h5A, "R6", "stored word cached", int'(cpu_rsp_rdata), 8'h5A);
    access(1'b0, 5'd1, '0);
    chk(last_hit == 1, "R8", "recently used block kept", last_hit, 1);
    access(1'b0, 5'd6, '0);
    chk(last_hit == 0, "R8", "LRU block replaced", last_hit, 0);
    access(1'b1, 5'd0, 8'hC3);
    chk(last_hit == 1, "R6", "store hit", last_hit, 1);
    access(1'b0, 5'd0, '0);
    chk(cpu_rsp_rdata == 8'hC3, "R6", "load after store hit", int'(cpu_rsp_rdata), 8'hC3);

    for (int p = 0; p < 3; p++) begin
      for (int i = 0; i < NWORDS; i++) begin
        logic [AW-1:0] a;
        a = (p == 0) ? AW'(i) : (p == 1) ? AW'((i * 13) % NWORDS) : AW'(NWORDS - 1 - i);
        access(i % 3 == 1, a, DW'(i * 5 + p));
      end
    end

    for (int i = 0; i < 300; i++) access(1'b0, 5'd2, '0);
    chk(hit_count == 8'hFF, "R9", "hit counter saturated", int'(hit_count), 255);
    for (int i = 0; i < 300; i++) access(1'b0, AW'((i % 3) * 2), '0);
    chk(miss_count == 8'hFF, "R9", "miss counter saturated", int'(miss_count), 255);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule